// File: doc/BRIEF.md
# Aliased Partial-Width Register File

This block holds a small set of 64-bit general-purpose registers that software-visible instructions can reach through several overlapping windows of different widths: the bottom byte, the byte just above it, the bottom half-word, the bottom word and the whole register. Each window is only a way of addressing part of one physical register. A narrow write merges its bits into the stored value and leaves every other bit as it was. A narrow read hands back only the chosen window, padded with zeros up to 64 bits.

Next to the general registers sits a second, independent bank of four 16-bit registers for segment-style values. These have their own index space, chosen by a bank-select bit on each port, and have no narrower or wider windows. The block has one write port and two read ports. Writes land on the rising clock edge. Reads are combinational and show the contents from before any write in the same cycle.

Top module: `arf_regfile`

## Requirements
- R1: There are four general registers, indexed 0 to 3, each 64 bits wide. View code 3'b100 reads and writes all of bits 63:0.
- R2: View code 3'b001 addresses bits 15:8. A write through it changes only those eight bits.
- R3: View code 3'b000 addresses bits 7:0. A write through it changes only bits 7:0, and later reads through the 16-bit and 32-bit views show the new low byte.
- R4: View code 3'b010 addresses bits 15:0 and view code 3'b011 addresses bits 31:0. A write through either changes only that slice.
- R5: A read through any view narrower than 64 bits returns the slice in the low bits of the read data, with every bit above the slice at zero.
- R6: View codes 3'b101, 3'b110 and 3'b111 are illegal. A general-bank write with such a code leaves every register unchanged. A general-bank read with such a code returns zero.
- R7: When the bank-select bit of a port is 1, the port addresses four separate 16-bit segment registers through the same 2-bit index. A segment write stores wr_data[15:0] whatever the view code. A segment read returns the register zero-extended to 64 bits whatever the view code. The two banks never affect each other.
- R8: A write takes effect on the rising clock edge when wr_en is 1. Reads are combinational, and a read of the register being written in the same cycle returns the old value.
- R9: While rst_n is 0 at a rising clock edge, every general and segment register is cleared to zero.
- R10: The two read ports work independently, each with its own bank select, index and view code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write enable |
| wr_seg | input | 1 | Write bank select: 1 = segment bank, 0 = general bank |
| wr_idx | input | 2 | Write register index |
| wr_view | input | 3 | Write view code |
| wr_data | input | 64 | Write data, right-aligned for narrow views |
| rd0_seg | input | 1 | Read port 0 bank select |
| rd0_idx | input | 2 | Read port 0 register index |
| rd0_view | input | 3 | Read port 0 view code |
| rd0_data | output | 64 | Read port 0 data, zero-extended |
| rd1_seg | input | 1 | Read port 1 bank select |
| rd1_idx | input | 2 | Read port 1 register index |
| rd1_view | input | 3 | Read port 1 view code |
| rd1_data | output | 64 | Read port 1 data, zero-extended |

## Verification
The assertions take for granted that every control input has a known 0 or 1 value at each clock edge, and that the view code and index are valid whenever wr_en is high. The illegal view codes are the one exception: they are permitted and must suppress the write. The stimulus drives every input from a defined value at the falling edge, lets the view code roam over all eight encodings so that illegal codes occur often, and keeps the index inside its two-bit range. Reset is applied once more mid-run with registers non-zero, so the clearing behaviour is seen from a known state.

// File: rtl/arf_pkg.sv
// Package: shared widths and the view-select encoding of the aliased register file.
// Assumes: the general registers are 64 bits and the segment registers are 16 bits.
package arf_pkg;

    localparam int DATA_W = 64;
    localparam int SEG_W  = 16;
    localparam int VIEW_W = 3;

    // Window selector for general-bank accesses; codes 5..7 are illegal.
    typedef enum logic [VIEW_W-1:0] {
        VW_LO8 = 3'b000,
        VW_HI8 = 3'b001,
        VW_W16 = 3'b010,
        VW_W32 = 3'b011,
        VW_W64 = 3'b100
    } view_e;

    // True for the five defined window codes.
    function automatic logic view_legal(input logic [VIEW_W-1:0] v);
        return (v <= 3'b100);
    endfunction

endpackage

// File: rtl/arf_view_read.sv
// Module: extracts one aliased window from a stored 64-bit word and zero-extends it.
// Assumes: the view code may be illegal, in which case the result is zero.
module arf_view_read
    import arf_pkg::*;
(
    input  logic [DATA_W-1:0] word_i,
    input  logic [VIEW_W-1:0] view_i,
    output logic [DATA_W-1:0] data_o
);

    // Select and right-align the window chosen by the view code.
    always_comb begin
        data_o = '0;
        case (view_i)
            VW_LO8:  data_o[7:0]  = word_i[7:0];
            VW_HI8:  data_o[7:0]  = word_i[15:8];
            VW_W16:  data_o[15:0] = word_i[15:0];
            VW_W32:  data_o[31:0] = word_i[31:0];
            VW_W64:  data_o       = word_i;
            default: data_o       = '0;
        endcase
    end

    // Guard: any window narrower than the full word leaves the top half clear.
    always_comb begin
        if (view_i != VW_W64) begin
            AST_RD_UPPER_ZERO: assert (data_o[DATA_W-1:32] == '0); // R5
        end
    end

endmodule

// File: rtl/arf_view_merge.sv
// Module: merges right-aligned write data into the chosen window of an existing word.
// Assumes: old_i is the current register contents; legal_o tells the caller whether to write.
module arf_view_merge
    import arf_pkg::*;
(
    input  logic [DATA_W-1:0] old_i,
    input  logic [DATA_W-1:0] new_i,
    input  logic [VIEW_W-1:0] view_i,
    output logic [DATA_W-1:0] merged_o,
    output logic              legal_o
);

    // Overlay the incoming bits onto the window and keep all others.
    always_comb begin
        merged_o = old_i;
        legal_o  = view_legal(view_i);
        case (view_i)
            VW_LO8:  merged_o[7:0]  = new_i[7:0];
            VW_HI8:  merged_o[15:8] = new_i[7:0];
            VW_W16:  merged_o[15:0] = new_i[15:0];
            VW_W32:  merged_o[31:0] = new_i[31:0];
            VW_W64:  merged_o       = new_i;
            default: merged_o       = old_i;
        endcase
    end

    // Guard: byte windows never disturb bits outside their own eight.
    always_comb begin
        if (view_i == VW_HI8) begin
            AST_HI8_KEEPS_REST: assert (merged_o[DATA_W-1:16] == old_i[DATA_W-1:16]
                                        && merged_o[7:0] == old_i[7:0]); // R2
        end
        if (view_i == VW_LO8) begin
            AST_LO8_KEEPS_REST: assert (merged_o[DATA_W-1:8] == old_i[DATA_W-1:8]); // R3
        end
        if (view_i == VW_W16 || view_i == VW_W32) begin
            AST_WIDE_KEEPS_TOP: assert (merged_o[DATA_W-1:32] == old_i[DATA_W-1:32]); // R4
        end
    end

endmodule

// File: rtl/arf_bank.sv
// Module: a bank of NREG flip-flop registers, one full-word write port and three read ports.
// Assumes: synchronous active-low reset; reads are combinational and show pre-write contents.
module arf_bank #(
    parameter int NREG = 4,
    parameter int W    = 64,
    localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [IW-1:0] widx_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [IW-1:0] ridx_a_i,
    input  logic [IW-1:0] ridx_b_i,
    input  logic [IW-1:0] ridx_c_i,
    output logic [W-1:0]  rdata_a_o,
    output logic [W-1:0]  rdata_b_o,
    output logic [W-1:0]  rdata_c_o
);

    logic [NREG-1:0][W-1:0] mem_q;

    // One storage process per register, loaded only when it is the write target.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (we_i && (widx_i == IW'(g))) begin
                mem_q[g] <= wdata_i;
            end
        end
    end

    // Combinational read ports straight from storage, no bypass.
    assign rdata_a_o = mem_q[ridx_a_i];
    assign rdata_b_o = mem_q[ridx_b_i];
    assign rdata_c_o = mem_q[ridx_c_i];

    // Guard: without a write strobe no register moves.
    AST_HOLD_WITHOUT_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(mem_q)); // R8

    // Guard: a strobed write is visible on the next cycle at the addressed entry.
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mem_q[$past(widx_i)] == $past(wdata_i))); // R1

endmodule

// File: rtl/arf_regfile.sv
// Module: top of the aliased register file: a 64-bit general bank with windowed views
//         and a separate 16-bit segment bank, one write port and two read ports.
// Assumes: synchronous active-low reset; inputs are stable around the rising edge.
module arf_regfile
    import arf_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_seg,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [2:0]        wr_view,
    input  logic [63:0]       wr_data,
    input  logic              rd0_seg,
    input  logic [IDX_W-1:0]  rd0_idx,
    input  logic [2:0]        rd0_view,
    output logic [63:0]       rd0_data,
    input  logic              rd1_seg,
    input  logic [IDX_W-1:0]  rd1_idx,
    input  logic [2:0]        rd1_view,
    output logic [63:0]       rd1_data
);

    localparam int NREG  = 2 ** IDX_W;
    localparam int NPORT = 2;

    // General bank write path.
    logic [DATA_W-1:0] gen_old;
    logic [DATA_W-1:0] gen_merged;
    logic              gen_legal;
    logic              gen_we;
    logic              seg_we;

    // Read-port request arrays, gathered so the port logic can be generated.
    logic [NPORT-1:0]             rp_seg;
    logic [NPORT-1:0][IDX_W-1:0]  rp_idx;
    logic [NPORT-1:0][VIEW_W-1:0] rp_view;
    logic [NPORT-1:0][DATA_W-1:0] rp_gen_raw;
    logic [NPORT-1:0][SEG_W-1:0]  rp_seg_raw;
    logic [NPORT-1:0][DATA_W-1:0] rp_gen_view;
    logic [NPORT-1:0][DATA_W-1:0] rp_out;
    logic [SEG_W-1:0]             seg_unused;

    // Pack the port inputs into arrays.
    assign rp_seg  = {rd1_seg,  rd0_seg};
    assign rp_idx  = {rd1_idx,  rd0_idx};
    assign rp_view = {rd1_view, rd0_view};

    // Merge incoming write data into the current contents of the target register.
    arf_view_merge i_merge (
        .old_i    (gen_old),
        .new_i    (wr_data),
        .view_i   (wr_view),
        .merged_o (gen_merged),
        .legal_o  (gen_legal)
    );

    // Route the write strobe to exactly one bank.
    assign gen_we = wr_en && !wr_seg && gen_legal;
    assign seg_we = wr_en && wr_seg;

    // General registers; the third read port feeds the write merge.
    arf_bank #(.NREG(NREG), .W(DATA_W)) i_gen_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (gen_we),
        .widx_i    (wr_idx),
        .wdata_i   (gen_merged),
        .ridx_a_i  (rp_idx[0]),
        .ridx_b_i  (rp_idx[1]),
        .ridx_c_i  (wr_idx),
        .rdata_a_o (rp_gen_raw[0]),
        .rdata_b_o (rp_gen_raw[1]),
        .rdata_c_o (gen_old)
    );

    // Segment registers; whole 16-bit writes, third read port idle.
    arf_bank #(.NREG(NREG), .W(SEG_W)) i_seg_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (seg_we),
        .widx_i    (wr_idx),
        .wdata_i   (wr_data[SEG_W-1:0]),
        .ridx_a_i  (rp_idx[0]),
        .ridx_b_i  (rp_idx[1]),
        .ridx_c_i  (wr_idx),
        .rdata_a_o (rp_seg_raw[0]),
        .rdata_b_o (rp_seg_raw[1]),
        .rdata_c_o (seg_unused)
    );

    // Per read port: window the general word, then choose the bank.
    for (genvar p = 0; p < NPORT; p++) begin : g_rport
        arf_view_read i_view (
            .word_i (rp_gen_raw[p]),
            .view_i (rp_view[p]),
            .data_o (rp_gen_view[p])
        );

        // Bank select: segment values are zero-extended, view code ignored.
        always_comb begin
            if (rp_seg[p]) begin
                rp_out[p] = {{(DATA_W-SEG_W){1'b0}}, rp_seg_raw[p]};
            end else begin
                rp_out[p] = rp_gen_view[p];
            end
        end
    end

    assign rd0_data = rp_out[0];
    assign rd1_data = rp_out[1];

    // Guard: an illegal view never strobes the general bank.
    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_seg && (wr_view > 3'b100)) |-> !gen_we); // R6

    // Guard: a segment write never strobes the general bank.
    AST_SEG_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_seg) |-> (!gen_we && seg_we)); // R7

    // Guard: a segment read never carries bits above 16.
    AST_SEG_READ_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        rd0_seg |-> (rd0_data[DATA_W-1:SEG_W] == '0)); // R7

endmodule

// File: tb/test_arf_regfile.sv
`timescale 1ns/1ps
module test_arf_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_seg = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [2:0]  wr_view = '0;
    logic [63:0] wr_data = '0;
    logic        rd0_seg = 1'b0;
    logic [1:0]  rd0_idx = '0;
    logic [2:0]  rd0_view = '0;
    logic [63:0] rd0_data;
    logic        rd1_seg = 1'b0;
    logic [1:0]  rd1_idx = '0;
    logic [2:0]  rd1_view = '0;
    logic [63:0] rd1_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [63:0] m_gen [4];
    logic [15:0] m_seg [4];

    always #2.5 clk = ~clk;

    arf_regfile i_arf_regfile (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_seg(wr_seg), .wr_idx(wr_idx), .wr_view(wr_view), .wr_data(wr_data),
        .rd0_seg(rd0_seg), .rd0_idx(rd0_idx), .rd0_view(rd0_view), .rd0_data(rd0_data),
        .rd1_seg(rd1_seg), .rd1_idx(rd1_idx), .rd1_view(rd1_view), .rd1_data(rd1_data)
    );

    // Expected read of one window from the model (R5, R6).
    function automatic logic [63:0] f_slice(input logic [63:0] w, input logic [2:0] v);
        case (v)
            3'b000:  return {56'd0, w[7:0]};
            3'b001:  return {56'd0, w[15:8]};
            3'b010:  return {48'd0, w[15:0]};
            3'b011:  return {32'd0, w[31:0]};
            3'b100:  return w;
            default: return 64'd0;
        endcase
    endfunction

    // Expected register after a general write (R1..R4, R6).
    function automatic logic [63:0] f_merge(input logic [63:0] o, input logic [63:0] d,
                                            input logic [2:0] v);
        case (v)
            3'b000:  return {o[63:8], d[7:0]};
            3'b001:  return {o[63:16], d[7:0], o[7:0]};
            3'b010:  return {o[63:16], d[15:0]};
            3'b011:  return {o[63:32], d[31:0]};
            3'b100:  return d;
            default: return o;
        endcase
    endfunction

    function automatic logic [63:0] f_expect(input logic s, input logic [1:0] i,
                                             input logic [2:0] v);
        if (s) return {48'd0, m_seg[i]};
        return f_slice(m_gen[i], v);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Read through both ports and compare with the model; called away from the edge.
    task automatic read2(input string req, input logic s0, input logic [1:0] i0,
                         input logic [2:0] v0, input logic s1, input logic [1:0] i1,
                         input logic [2:0] v1);
        rd0_seg = s0; rd0_idx = i0; rd0_view = v0;
        rd1_seg = s1; rd1_idx = i1; rd1_view = v1;
        #0.5;
        check(req, rd0_data, f_expect(s0, i0, v0));
        check(req, rd1_data, f_expect(s1, i1, v1));
    endtask

    // One write cycle driven at the falling edge; model updated after the rising edge.
    task automatic write1(input logic s, input logic [1:0] i, input logic [2:0] v,
                          input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_seg = s; wr_idx = i; wr_view = v; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (s) m_seg[i] = d[15:0];
        else   m_gen[i] = f_merge(m_gen[i], d, v);
    endtask

    task automatic clear_model();
        for (int k = 0; k < 4; k++) begin
            m_gen[k] = '0;
            m_seg[k] = '0;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state, every register in both banks reads zero.
        for (int k = 0; k < 4; k++) read2("R9 reset", 1'b0, 2'(k), 3'b100, 1'b1, 2'(k), 3'b000);

        // R1: full write and read.
        write1(1'b0, 2'd0, 3'b100, 64'h0123_4567_89AB_CDEF);
        read2("R1 full", 1'b0, 2'd0, 3'b100, 1'b0, 2'd1, 3'b100);

        // R2: high byte write touches only bits 15:8.
        write1(1'b0, 2'd0, 3'b001, 64'hFFFF_FFFF_FFFF_FF5A);
        read2("R2 hi8", 1'b0, 2'd0, 3'b100, 1'b0, 2'd0, 3'b001);
        check("R2 hi8 value", rd0_data, 64'h0123_4567_89AB_5AEF);

        // R3: low byte write shows through 16-bit and 32-bit views.
        write1(1'b0, 2'd0, 3'b000, 64'h0000_0000_0000_00C3);
        read2("R3 lo8", 1'b0, 2'd0, 3'b010, 1'b0, 2'd0, 3'b011);
        check("R3 w16 value", rd0_data, 64'h0000_0000_0000_5AC3);
        check("R3 w32 value", rd1_data, 64'h0000_0000_89AB_5AC3);

        // R4: 16-bit and 32-bit writes keep the upper bits.
        write1(1'b0, 2'd2, 3'b100, 64'hAAAA_AAAA_AAAA_AAAA);
        write1(1'b0, 2'd2, 3'b010, 64'h1111_1111_1111_2222);
        write1(1'b0, 2'd3, 3'b100, 64'h5555_5555_5555_5555);
        write1(1'b0, 2'd3, 3'b011, 64'h9999_9999_3333_4444);
        read2("R4 slices", 1'b0, 2'd2, 3'b100, 1'b0, 2'd3, 3'b100);
        check("R4 w16 value", rd0_data, 64'hAAAA_AAAA_AAAA_2222);
        check("R4 w32 value", rd1_data, 64'h5555_5555_3333_4444);

        // R5: narrow reads zero-extend.
        read2("R5 zero-ext", 1'b0, 2'd3, 3'b000, 1'b0, 2'd3, 3'b001);
        check("R5 hi8 value", rd1_data, 64'h0000_0000_0000_0044);

        // R6: illegal write ignored, illegal read gives zero.
        write1(1'b0, 2'd3, 3'b110, 64'hDEAD_BEEF_DEAD_BEEF);
        read2("R6 illegal", 1'b0, 2'd3, 3'b100, 1'b0, 2'd3, 3'b111);
        check("R6 illegal read", rd1_data, 64'd0);

        // R7: segment bank separate, 16 bits, view ignored.
        write1(1'b1, 2'd3, 3'b111, 64'hFFFF_FFFF_FFFF_BEEF);
        read2("R7 seg", 1'b1, 2'd3, 3'b000, 1'b0, 2'd3, 3'b100);
        check("R7 seg value", rd0_data, 64'h0000_0000_0000_BEEF);
        check("R7 gen untouched", rd1_data, 64'h5555_5555_3333_4444);

        // R8: same-cycle read shows old value, new value after the edge.
        @(negedge clk);
        wr_en = 1'b1; wr_seg = 1'b0; wr_idx = 2'd1; wr_view = 3'b100;
        wr_data = 64'hCAFE_F00D_1234_5678;
        read2("R8 no bypass", 1'b0, 2'd1, 3'b100, 1'b0, 2'd1, 3'b011);
        @(negedge clk);
        wr_en = 1'b0;
        m_gen[1] = 64'hCAFE_F00D_1234_5678;
        read2("R8 after edge", 1'b0, 2'd1, 3'b100, 1'b0, 2'd1, 3'b001);

        // R10: independent ports on different banks and registers.
        read2("R10 ports", 1'b1, 2'd3, 3'b100, 1'b0, 2'd0, 3'b001);

        // Random mixed-width writes, every view checked on both ports.
        for (int n = 0; n < 400; n++) begin
            logic s;
            logic [1:0] i;
            logic [2:0] v;
            logic [63:0] d;
            s = ($urandom_range(0, 4) == 0);
            i = 2'($urandom_range(0, 3));
            v = 3'($urandom_range(0, 7));
            d = {$urandom, $urandom};
            write1(s, i, v, d);
            for (int vv = 0; vv < 8; vv++) begin
                read2("R1 R2 R3 R4 R6 random", 1'b0, i, 3'(vv), 1'b0, 2'(~i), 3'(7 - vv));
            end
            read2("R7 R10 random", 1'b1, i, v, 1'b1, 2'(i + 2'd1), 3'b100);
        end

        // R9: reset again from non-zero contents.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        clear_model();
        for (int k = 0; k < 4; k++) read2("R9 re-reset", 1'b0, 2'(k), 3'b100, 1'b1, 2'(k), 3'b100);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule